// File: doc/BRIEF.md
# Square-Wave Tone and Noise Channel Generator

This block produces the raw waveforms of a three-voice sound generator. Each voice has its own 12-bit period and a counter that toggles a square-wave bit. One shared pseudo-random noise bit comes from a 17-bit linear-feedback shift register, which advances at a rate set by a 5-bit period. A 6-bit mixer word gates the tone and noise onto each of the three channel outputs. The outputs take the values 0 and 1 only, with no DC offset.

Every counter advances on a common tick from a master prescaler. A 2-bit select input picks the prescaler ratio. In the standard ratio, a tone period of P gives a full square wave of 16·P input clocks, so 440 Hz at a 2 MHz clock needs P = 284. Volume, envelope shaping, register access and any analog or PWM conversion belong to other blocks.

Top module: `psg_tone_noise`

## Requirements
- R1: After synchronous reset all tone bits are 0 and the noise register holds 1, so the noise bit is 1. With mixer 6'b111_010, the outputs right after reset are chan_out = 3'b010.
- R2: A tone channel with period P (P ≥ 1) toggles its square-wave bit once every P prescaler ticks. The first toggle takes the bit from 0 to 1 after P ticks.
- R3: A tone or noise period of 0 behaves exactly like a period of 1.
- R4: prescale_sel picks the tick rate. Codes 2'b00 and 2'b11 tick once every 8 clocks, 2'b01 ticks on every clock, and 2'b10 ticks once every 128 clocks. The first tick after reset lands on clock edge 8, 1 or 128 respectively.
- R5: The three tone channels run independently, each from its own period input (A on chan_out[0], B on [1], C on [2]).
- R6: Mixer bits [2:0] are the tone-off flags and bits [5:3] are the noise-off flags, bit 0 and bit 3 belonging to channel A. A set flag disables that source. chan_out[i] = (tone_i | tone_off_i) & (noise | noise_off_i).
- R7: A channel with both of its flags set outputs a constant 1.
- R8: On each noise step the register shifts right by one, and bit 0 XOR bit 3 enters at bit 16. The noise bit is register bit 0.
- R9: The noise register steps once every 2·max(N,1) prescaler ticks, where N is the noise period. The first step comes 2·max(N,1) ticks after reset.
- R10: If a tone period is lowered to a value at or below the channel's current count, the bit toggles on the next tick and the count restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prescale_sel | input | 2 | Prescaler ratio select |
| period_a | input | TONE_W | Tone period, channel A |
| period_b | input | TONE_W | Tone period, channel B |
| period_c | input | TONE_W | Tone period, channel C |
| noise_period | input | NOISE_W | Noise step period |
| mixer | input | 6 | Tone-off [2:0] and noise-off [5:3] flags |
| chan_out | output | 3 | Mixed channel waveforms, C..A |

## Verification
The bench builds the block with its defaults: 12-bit tone periods, a 5-bit noise period, and prescaler ratios of 8 and 128. With these values the longest tone period, 4095, can be measured end to end in bypass mode. The divide-by-128 ratio can be checked on a full square-wave cycle without exceeding the run budget. Bypass mode also puts every tick on a clock edge, so the noise sequence and the tone-and-noise product can be checked edge by edge against a model of the shift register kept in the bench.

// File: rtl/psg_pkg.sv
package psg_pkg;

    localparam int NUM_CH = 3;
    localparam int LFSR_W = 17;
    localparam logic [LFSR_W-1:0] LFSR_SEED = LFSR_W'(1);

    typedef enum logic [1:0] {
        PRE_STD_LO = 2'b00,
        PRE_BYPASS = 2'b01,
        PRE_SLOW   = 2'b10,
        PRE_STD_HI = 2'b11
    } prescale_e;

    typedef struct packed {
        logic [NUM_CH-1:0] noise_off;
        logic [NUM_CH-1:0] tone_off;
    } mixer_t;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[0] ^ s[3], s[LFSR_W-1:1]};
    endfunction

    function automatic logic mix_bit(input logic tone, input logic noise,
                                     input logic toff, input logic noff);
        return (tone | toff) & (noise | noff);
    endfunction

endpackage

// File: rtl/psg_prescaler.sv
module psg_prescaler
    import psg_pkg::*;
#(
    parameter int DIV_STD  = 8,
    parameter int DIV_SLOW = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int CW = $clog2(DIV_SLOW);

    prescale_e      mode;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  lim;

    assign mode = prescale_e'(sel);

    always_comb begin
        case (mode)
            PRE_BYPASS: lim = '0;
            PRE_SLOW:   lim = CW'(DIV_SLOW - 1);
            default:    lim = CW'(DIV_STD - 1);
        endcase
    end

    assign tick = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + CW'(1);
    end

    // R4: two ticks in a row only happen in bypass mode
    a_r4_back_to_back_bypass: assert property (@(posedge clk) disable iff (rst)
        (tick && $past(tick)) |-> (sel == 2'b01));

endmodule

// File: rtl/psg_tone_gen.sv
module psg_tone_gen #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] period,
    output logic         tone
);
    logic [W-1:0] cnt;
    logic [W-1:0] eff;
    logic [W:0]   nxt;
    logic         wrap;

    assign eff  = (period == '0) ? W'(1) : period;
    assign nxt  = {1'b0, cnt} + (W+1)'(1);
    assign wrap = (nxt >= {1'b0, eff});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tone <= 1'b0;
        end else if (tick) begin
            if (wrap) begin
                cnt  <= '0;
                tone <= ~tone;
            end else begin
                cnt  <= nxt[W-1:0];
            end
        end
    end

    // R2: the square-wave bit only moves on a prescaler tick
    a_r2_toggle_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$stable(tone) |-> $past(tick));

    // R10: a tick with the count at or past the period always restarts the count
    a_r10_wrap_restarts: assert property (@(posedge clk) disable iff (rst)
        (tick && wrap) |=> (cnt == '0));

endmodule

// File: rtl/psg_noise_gen.sv
module psg_noise_gen
    import psg_pkg::*;
#(
    parameter int NW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [NW-1:0] period,
    output logic          noise
);
    logic              half;
    logic [NW-1:0]     cnt;
    logic [NW-1:0]     eff;
    logic [NW:0]       nxt;
    logic [LFSR_W-1:0] lfsr;
    logic              adv;
    logic              wrap;

    assign eff   = (period == '0) ? NW'(1) : period;
    assign nxt   = {1'b0, cnt} + (NW+1)'(1);
    assign wrap  = (nxt >= {1'b0, eff});
    assign adv   = tick & half;
    assign noise = lfsr[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            half <= 1'b0;
            cnt  <= '0;
            lfsr <= LFSR_SEED;
        end else begin
            if (tick) half <= ~half;
            if (adv) begin
                if (wrap) begin
                    cnt  <= '0;
                    lfsr <= lfsr_step(lfsr);
                end else begin
                    cnt  <= nxt[NW-1:0];
                end
            end
        end
    end

    // R8: the shift register can never lock up at zero
    a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        lfsr != '0);

    // R9: the register steps only on an every-other-tick advance
    a_r9_step_on_half_rate: assert property (@(posedge clk) disable iff (rst)
        !$stable(lfsr) |-> $past(tick && half));

endmodule

// File: rtl/psg_tone_noise.sv
module psg_tone_noise
    import psg_pkg::*;
#(
    parameter int TONE_W   = 12,
    parameter int NOISE_W  = 5,
    parameter int DIV_STD  = 8,
    parameter int DIV_SLOW = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         prescale_sel,
    input  logic [TONE_W-1:0]  period_a,
    input  logic [TONE_W-1:0]  period_b,
    input  logic [TONE_W-1:0]  period_c,
    input  logic [NOISE_W-1:0] noise_period,
    input  logic [5:0]         mixer,
    output logic [2:0]         chan_out
);
    logic                tick;
    logic                noise;
    logic [NUM_CH-1:0]   tone;
    logic [TONE_W-1:0]   per [NUM_CH];
    mixer_t              mx;

    assign per[0] = period_a;
    assign per[1] = period_b;
    assign per[2] = period_c;
    assign mx     = mixer_t'(mixer);

    psg_prescaler #(.DIV_STD(DIV_STD), .DIV_SLOW(DIV_SLOW)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (prescale_sel),
        .tick (tick)
    );

    psg_noise_gen #(.NW(NOISE_W)) u_noise (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .period (noise_period),
        .noise  (noise)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        psg_tone_gen #(.W(TONE_W)) u_tone (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .period (per[i]),
            .tone   (tone[i])
        );

        assign chan_out[i] = mix_bit(tone[i], noise, mx.tone_off[i], mx.noise_off[i]);

        // R7: both sources disabled leaves the channel high
        a_r7_both_off_high: assert property (@(posedge clk) disable iff (rst)
            (mx.tone_off[i] && mx.noise_off[i]) |-> chan_out[i]);

        // R6: an enabled tone source that is low forces the channel low
        a_r6_tone_gates: assert property (@(posedge clk) disable iff (rst)
            (!mx.tone_off[i] && !tone[i]) |-> !chan_out[i]);
    end

endmodule

// File: tb/psg_tone_noise_test.sv
`timescale 1ns/1ps
module psg_tone_noise_test;

    typedef struct packed {
        logic [1:0]  sel;
        logic [11:0] pa;
        logic [11:0] pb;
        logic [11:0] pc;
        logic [7:0]  div;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 12'd1,    12'd2, 12'd3,   8'd1},
        '{2'b01, 12'd0,    12'd0, 12'd4,   8'd1},
        '{2'b00, 12'd3,    12'd1, 12'd2,   8'd8},
        '{2'b11, 12'd2,    12'd5, 12'd1,   8'd8},
        '{2'b10, 12'd1,    12'd2, 12'd1,   8'd128},
        '{2'b01, 12'd4095, 12'd7, 12'd300, 8'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  prescale_sel = 2'b01;
    logic [11:0] period_a = '0, period_b = '0, period_c = '0;
    logic [4:0]  noise_period = '0;
    logic [5:0]  mixer = '0;
    logic [2:0]  chan_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    psg_tone_noise uut (
        .clk(clk), .rst(rst), .prescale_sel(prescale_sel),
        .period_a(period_a), .period_b(period_b), .period_c(period_c),
        .noise_period(noise_period), .mixer(mixer), .chan_out(chan_out)
    );

    function automatic int eff(input int p);
        return (p == 0) ? 1 : p;
    endfunction

    function automatic logic [16:0] step17(input logic [16:0] s);
        return {s[0] ^ s[3], s[16:1]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic tick_edge();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin : main
        logic [16:0] m;
        @(negedge clk);

        // R1, R6: reset state with mixer 111_010 -> B forced high, A/C tone low
        mixer = 6'b111_010;
        do_reset();
        check(chan_out == 3'b010, "R1/R6 reset outputs", chan_out, 3'b010);

        // R2, R3, R4, R5: vector table, tone only
        for (int v = 0; v < NV; v++) begin
            int rise [3];
            int fall [3];
            int exp  [3];
            int e;
            int lim;
            prescale_sel = VECS[v].sel;
            period_a = VECS[v].pa;
            period_b = VECS[v].pb;
            period_c = VECS[v].pc;
            mixer    = 6'b111_000;
            exp[0] = int'(VECS[v].div) * eff(int'(VECS[v].pa));
            exp[1] = int'(VECS[v].div) * eff(int'(VECS[v].pb));
            exp[2] = int'(VECS[v].div) * eff(int'(VECS[v].pc));
            lim = 2 * ((exp[0] > exp[1]) ? ((exp[0] > exp[2]) ? exp[0] : exp[2])
                                         : ((exp[1] > exp[2]) ? exp[1] : exp[2])) + 4;
            for (int c = 0; c < 3; c++) begin
                rise[c] = -1;
                fall[c] = -1;
            end
            do_reset();
            check(chan_out == 3'b000, "R1 tone bits zero after reset", chan_out, 0);
            e = 0;
            while (e < lim && (fall[0] < 0 || fall[1] < 0 || fall[2] < 0)) begin
                tick_edge();
                e++;
                for (int c = 0; c < 3; c++) begin
                    if (rise[c] < 0 && chan_out[c]) rise[c] = e;
                    else if (rise[c] >= 0 && fall[c] < 0 && !chan_out[c]) fall[c] = e;
                end
            end
            for (int c = 0; c < 3; c++) begin
                check(rise[c] == exp[c], "R2/R4/R5 first rise edge", rise[c], exp[c]);
                check(fall[c] == 2 * exp[c], "R2/R3/R5 first fall edge", fall[c], 2 * exp[c]);
            end
        end

        // R8, R9: noise only on A, N=3, bypass; B,C fully disabled
        prescale_sel = 2'b01;
        noise_period = 5'd3;
        mixer = 6'b110_111;
        do_reset();
        m = 17'd1;
        check(chan_out == {2'b11, m[0]}, "R8 noise seed", chan_out, {2'b11, m[0]});
        for (int e = 1; e <= 120; e++) begin
            tick_edge();
            if (e % 6 == 0) m = step17(m);
            check(chan_out == {2'b11, m[0]}, "R8/R9/R7 noise sequence N=3", chan_out, {2'b11, m[0]});
        end

        // R3, R9: noise period 0 behaves like 1
        noise_period = 5'd0;
        do_reset();
        m = 17'd1;
        for (int e = 1; e <= 40; e++) begin
            tick_edge();
            if (e % 2 == 0) m = step17(m);
            check(chan_out[0] == m[0], "R3/R9 noise period zero", chan_out[0], m[0]);
        end

        // R6: tone and noise both enabled on every channel
        period_a = 12'd1;
        period_b = 12'd4095;
        period_c = 12'd4095;
        noise_period = 5'd1;
        mixer = 6'b000_000;
        do_reset();
        m = 17'd1;
        for (int e = 1; e <= 40; e++) begin
            logic t;
            tick_edge();
            if (e % 2 == 0) m = step17(m);
            t = logic'(e % 2);
            check(chan_out == {2'b00, t & m[0]}, "R6 tone AND noise", chan_out, {2'b00, t & m[0]});
        end

        // R10: lowering the period below the running count
        period_a = 12'd100;
        mixer = 6'b111_000;
        do_reset();
        repeat (50) tick_edge();
        check(chan_out[0] == 1'b0, "R10 before period change", chan_out[0], 0);
        period_a = 12'd10;
        tick_edge();
        check(chan_out[0] == 1'b1, "R10 toggle on next tick", chan_out[0], 1);
        repeat (9) tick_edge();
        check(chan_out[0] == 1'b1, "R10 holds for new period", chan_out[0], 1);
        tick_edge();
        check(chan_out[0] == 1'b0, "R10 next toggle after new period", chan_out[0], 0);

        // R7: both sources off stays high across tone activity
        period_a = 12'd1;
        period_b = 12'd1;
        period_c = 12'd1;
        mixer = 6'b111_111;
        do_reset();
        for (int e = 0; e < 8; e++) begin
            check(chan_out == 3'b111, "R7 constant high", chan_out, 3'b111);
            tick_edge();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule